// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master that a host uses to read and write the 16-bit configuration registers of Ethernet PHY devices. A single two-wire bus carries a clock (MDC), which only the master generates, and one data line (MDIO) shared in both directions. Up to 32 PHYs can sit on the bus. Each one answers to a 5-bit address, and each has 32 registers selected by a second 5-bit field.

The host issues one transaction at a time. It presents a single-cycle request that carries:
- the direction (read or write);
- the device address;
- the register address;
- the write word;
- a flag that drops the 32-bit preamble for this transaction only.

The block divides the system clock down to MDC and shifts out the serial frame. The frame is 64 bits when the preamble is sent and 32 bits when it is suppressed. On reads the block releases the data line for the bus-turnaround and data phases and gathers the 16 bits the PHY returns. A one-cycle done pulse closes every transaction, and a read result stays on its output until the next read finishes.

Top module: `mdio_master`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, busy, done, mdc and mdio_oe are 0 and rd_data is 0.
- R2: A request (req_valid high) is accepted only while busy is low, and busy is high in the cycle after acceptance. Requests presented while busy is high have no effect on the frame in progress and produce no extra done pulse.
- R3: While busy, MDC is a square wave with a period of 2*CLK_DIV system clocks, starting low. While idle, MDC is held low.
- R4: MDIO changes only together with a falling MDC transition. The first frame bit is driven from the cycle after acceptance, before the first MDC rise. Bits go out most significant first.
- R5: With req_short low, the frame is 64 bits: 32 ones, then start 01, then opcode 01 (write) or 10 (read), then the 5-bit PHY address MSB first, then the 5-bit register address MSB first, then the 2-bit turnaround, then the 16 data bits.
- R6: With req_short high, the preamble is left out and the frame is 32 bits long. It begins directly with the start bits 01.
- R7: On a write, the master drives every bit. The turnaround is 1 then 0, followed by req_wdata MSB first.
- R8: On a read, mdio_oe is low for the final 18 bit periods. The 16 data bits are sampled from mdio_i at the MDC rising edges, MSB first, and presented on rd_data.
- R9: done is high for exactly one cycle, in the cycle after the MDC fall that ends the last bit. busy is low in that same cycle. rd_data keeps its value through later writes until another read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_short | input | 1 | 1 = omit the preamble for this transaction |
| req_phy | input | 5 | PHY device address |
| req_reg | input | 5 | Register address inside the PHY |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A bit counter that is off by one shows up at the ports as a frame of the wrong length, seen at the PHY as extra or missing MDC rises. It also moves the release point of mdio_oe. Both become visible within one transaction, at the latest when done arrives. A broken direction or field ordering shows up as a wrong bit at a specific MDC rise, and the bench reports it when done arrives for that transaction. A capture window that is shifted, or a result register that updates at the wrong time, shows up as a wrong rd_data word. A wrong divider count shows up at the second MDC rise as a period error.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_W    = 32;
  localparam int BODY_W   = 32;
  localparam int FRAME_W  = PRE_W + BODY_W;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int TA_W     = 2;
  localparam int RELEASE_BITS = TA_W + DATA_W;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic              rd;
    logic              short_pre;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          term;

  always_comb begin
    term      = (cnt == CW'(DIV - 1));
    rise_tick = en && term && !mdc;
    fall_tick = en && term && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
(
  input  mdio_req_t          req,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  logic [BODY_W-1:0] body;
  logic [1:0]        op;
  logic [TA_W-1:0]   ta;
  logic [DATA_W-1:0] dat;

  always_comb begin
    op  = req.rd ? OP_RD : OP_WR;
    ta  = req.rd ? 2'b11 : 2'b10;
    dat = req.rd ? {DATA_W{1'b1}} : req.wdata;
    body = {2'b01, op, req.phy, req.regad, ta, dat};
    if (req.short_pre) begin
      frame = {body, {PRE_W{1'b1}}};
      len   = LEN_W'(BODY_W);
    end else begin
      frame = {{PRE_W{1'b1}}, body};
      len   = LEN_W'(FRAME_W);
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic [W-1:0]  load_val,
  input  logic [CW-1:0] load_len,
  output logic          bit_out,
  output logic [CW-1:0] remain
);
  logic [W-1:0] sr;

  assign bit_out = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      remain <= '0;
    end else if (load) begin
      sr     <= load_val;
      remain <= load_len;
    end else if (shift) begin
      sr     <= {sr[W-2:0], 1'b1};
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic              req_short,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_req_t          req;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic [LEN_W-1:0]   remain;
  logic               accept, rise_tick, fall_tick, rd_op;
  logic [DATA_W-1:0]  cap;

  assign req    = '{rd: req_read, short_pre: req_short, phy: req_phy,
                    regad: req_reg, wdata: req_wdata};
  assign accept = req_valid && !busy;

  mdio_framer u_framer (.req(req), .frame(frame), .len(len));

  mdio_clkgen #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst(rst), .en(busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shifter #(.W(FRAME_W), .CW(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .shift(fall_tick),
    .load_val(frame), .load_len(len), .bit_out(mdio_o), .remain(remain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_op   <= 1'b0;
      mdio_oe <= 1'b0;
      cap     <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        rd_op   <= req_read;
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise_tick && rd_op && remain <= LEN_W'(DATA_W))
          cap <= {cap[DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (remain == LEN_W'(1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            if (rd_op) rd_data <= cap;
          end else begin
            mdio_oe <= !(rd_op && (remain - 1'b1) <= LEN_W'(RELEASE_BITS));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R4
  mdio_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
  // R4
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mdio_oe && !mdc));
  // R8
  oe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_read = 0, req_short = 0;
  logic [4:0] req_phy = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic busy, done, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  mdio_master #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_short(req_short), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, dones = 0, issued = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] bits;
    int          len;
    logic        rd;
    logic [15:0] rdexp;
  } item_t;
  item_t exp_q[$];

  // behavioural PHY
  logic cur_rd = 0;
  int   cur_len = 64;
  logic [15:0] cur_resp = 0;
  logic phy_en = 0, phy_val = 1;
  logic cap_o[64];
  logic cap_oe[64];
  int   cap_n = 0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always @(posedge mdc) begin
    if (cap_n < 64) begin
      cap_o[cap_n]  = mdio_o;
      cap_oe[cap_n] = mdio_oe;
    end
    cap_n++;
  end

  always @(negedge mdc) begin
    if (cur_rd && cap_n >= cur_len - 17 && cap_n < cur_len) begin
      phy_en  = 1;
      phy_val = (cap_n == cur_len - 17) ? 1'b0 : cur_resp[cur_len - 1 - cap_n];
    end else phy_en = 0;
  end

  // monitor / scoreboard
  logic prev_done = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check("R9 done width", 2, 1);
      if (done) begin
        dones++;
        check("R9 busy low at done", {63'b0, busy}, 0);
        if (exp_q.size() == 0) check("R2 unexpected done", 1, 0);
        else begin
          item_t it;
          logic [63:0] got_b, exp_b, got_oe, exp_oe;
          it = exp_q.pop_front();
          check(it.len == 64 ? "R5 frame length" : "R6 frame length", cap_n, it.len);
          got_b = 0; exp_b = 0; got_oe = 0; exp_oe = 0;
          for (int i = 0; i < it.len && i < 64; i++) begin
            logic drv;
            drv = !(it.rd && i >= it.len - 18);
            exp_oe[i] = drv;
            got_oe[i] = cap_oe[i];
            if (drv) begin
              exp_b[i] = it.bits[63 - i];
              got_b[i] = cap_o[i];
            end
          end
          check(it.rd ? "R8 oe release" : "R7 oe driven", got_oe, exp_oe);
          check(it.len == 64 ? "R5 R7 frame bits" : "R6 R7 frame bits", got_b, exp_b);
          check(it.rd ? "R8 rd_data" : "R9 rd_data held", {48'b0, rd_data}, {48'b0, it.rdexp});
        end
        cap_n = 0;
      end
    end
    prev_done = done;
  end

  logic [15:0] last_rd = 0;

  task automatic issue(logic rd, logic sh, logic [4:0] phy, logic [4:0] rg,
                       logic [15:0] wd, logic [15:0] resp, logic poke);
    item_t it;
    int n;
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    it.bits = 0; n = 0;
    if (!sh) begin
      for (int i = 0; i < 32; i++) begin it.bits[63 - n] = 1; n++; end
    end
    it.bits[63 - n] = 0; n++; it.bits[63 - n] = 1; n++;
    it.bits[63 - n] = rd; n++; it.bits[63 - n] = !rd; n++;
    for (int i = 4; i >= 0; i--) begin it.bits[63 - n] = phy[i]; n++; end
    for (int i = 4; i >= 0; i--) begin it.bits[63 - n] = rg[i]; n++; end
    it.bits[63 - n] = 1; n++; it.bits[63 - n] = 0; n++;
    for (int i = 15; i >= 0; i--) begin it.bits[63 - n] = wd[i]; n++; end
    it.len = sh ? 32 : 64;
    it.rd = rd;
    if (rd) last_rd = resp;
    it.rdexp = last_rd;
    cur_rd = rd; cur_len = it.len; cur_resp = resp;
    exp_q.push_back(it);
    issued++;
    req_valid = 1; req_read = rd; req_short = sh;
    req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check("R2 busy after accept", {63'b0, busy}, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_valid = 1; req_read = !rd; req_short = !sh;
      req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset outputs", {busy, done, mdc, mdio_oe, rd_data}, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {busy, done, mdc, mdio_oe, rd_data}, 0);

    issue(0, 0, 5'h1F, 5'h00, 16'hA5C3, 16'h0, 0);
    issue(1, 0, 5'h00, 5'h1F, 16'h0, 16'h1234, 0);
    begin : period_r3
      time t0;
      @(posedge mdc); t0 = $time;
      @(posedge mdc);
      check("R3 mdc period", $time - t0, 2 * DIV * CLK_PERIOD);
    end
    issue(0, 1, 5'h0A, 5'h15, 16'h0001, 16'h0, 1);
    issue(1, 1, 5'h13, 5'h0C, 16'h0, 16'h8001, 0);
    issue(1, 0, 5'h05, 5'h1A, 16'h0, 16'hC3A5, 0);
    issue(0, 0, 5'h11, 5'h02, 16'hFFFF, 16'h0, 0);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R3 mdc idle low", {63'b0, mdc}, 0);
    check("R2 done count", dones, issued);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule